// File: doc/BRIEF.md
# CAN Mailbox Transmit Status Registers

This block keeps two status bits for each transmit-capable mailbox of a 32-mailbox CAN controller. One bit records that the mailbox's frame went out successfully. The other records that its transmission was given up. The protocol engine reports each outcome as a single-cycle event pulse tagged with a mailbox index. The top mailbox, index 31, can only receive, so events that name it are dropped.

Software reads and clears the status through a small word-addressed register bus, and reads and writes happen in the same cycle. Each status bit can be cleared in two ways. One is a write-one-to-clear on the status register itself. The other is a write of one to the same mailbox's bit in the transmit-request register, which clears both of that mailbox's status bits.

Completions pass through a per-mailbox mask into a transmit interrupt flag register, which drives the completion interrupt. Aborts set one global abort flag, and that flag reaches the global interrupt through its own mask. The event inputs carry no ready signal because the block accepts an event in every cycle, so there is never back-pressure. The bus is a plain select/write strobe and is always accepted in one cycle.

Register map (word address on `bus_addr`):
- 0: transmit request, bits 30..0, read/write.
- 1: transmit-done status, bits 30..0, write-one-to-clear.
- 2: abort status, bits 30..0, write-one-to-clear.
- 3: per-mailbox completion interrupt mask, bits 30..0, read/write.
- 4: completion interrupt flags, bits 30..0, write-one-to-clear.
- 5: global abort interrupt mask, bit 0, read/write.
- 6: global abort flag, bit 0, write-one-to-clear.

All other bits read zero.

Top module: `can_tx_status`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: A `done_vld` pulse with index n (n < 31) sets bit n of the transmit-done status (address 1) at the next clock edge.
- R3: An `abort_vld` pulse with index n (n < 31) sets bit n of the abort status (address 2) at the next clock edge.
- R4: An event whose index is 31 changes no status bit and no flag.
- R5: Writing one to a bit of address 1 or 2 clears that bit. Writing zero to a bit leaves it unchanged.
- R6: Writing one to bit n of the transmit-request register (address 0) clears bit n of both address 1 and address 2, and the written value reads back. Writing zero clears nothing.
- R7: When an event sets a bit in the same cycle as a clear of that bit, the bit ends up set.
- R8: A completion on mailbox n sets bit n of the flag register (address 4) only when bit n of the mask (address 3) is one.
- R9: A valid abort event sets the global abort flag (address 6, bit 0). `irq_global` is high only while that flag and the global mask (address 5, bit 0) are both one.
- R10: `irq_txdone` is high while any bit of address 4 is one. It stays high until software clears every such bit by write-one-to-clear.
- R11: Bit 31 of every register reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_vld | input | 1 | Successful-transmission event pulse |
| done_idx | input | 5 | Mailbox index of the completion event |
| abort_vld | input | 1 | Abandoned-transmission event pulse |
| abort_idx | input | 5 | Mailbox index of the abort event |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq_txdone | output | 1 | Transmission-completion interrupt |
| irq_global | output | 1 | Global abort interrupt |

## Verification
A status bit held in the wrong state shows up at the very next register read of address 1 or 2, because reads are combinational. A flag held in the wrong state shows up at the interrupt pins one edge after the event that caused it. A decoder that accepts index 31, or that lets a clear win over a set, leaves a bit set or missing in the readback in the cycle right after the collision. A cross-clear that is missing or too wide shows up as extra or missing bits in both status registers after a single transmit-request write.

// File: rtl/can_txstat_pkg.sv
package can_txstat_pkg;
  localparam int MB_COUNT = 32;
  localparam int IDX_W    = $clog2(MB_COUNT);
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_TXREQ  = 3'd0,
    RA_DONE   = 3'd1,
    RA_ABORT  = 3'd2,
    RA_MBMASK = 3'd3,
    RA_TXFLAG = 3'd4,
    RA_GMASK  = 3'd5,
    RA_GFLAG  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/mb_index_decode.sv
module mb_index_decode #(
  parameter int N_OUT = 31,
  parameter int IDX_W = 5
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic [N_OUT-1:0] hit
);
  // indexes at or above N_OUT match no output and are dropped
  for (genvar g = 0; g < N_OUT; g++) begin : g_hit
    assign hit[g] = vld && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/w1c_status_bank.sv
module w1c_status_bank #(
  parameter int WIDTH = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] sts_q
);
  logic [WIDTH-1:0] sts_d;

  // a set in the same cycle as a clear keeps the bit
  always_comb sts_d = (sts_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((sts_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> (sts_q == $past(sts_q)));
endmodule

// File: rtl/can_tx_status.sv
module can_tx_status
  import can_txstat_pkg::*;
#(
  parameter int NUM_MB = MB_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_vld,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              abort_vld,
  input  logic [IDX_W-1:0]  abort_idx,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_txdone,
  output logic              irq_global
);
  localparam int TX_MB = NUM_MB - 1;

  logic [TX_MB-1:0] done_hit, abort_hit;
  logic [TX_MB-1:0] txreq_q, mbmask_q;
  logic [TX_MB-1:0] done_sts, abort_sts, txflag_q;
  logic [TX_MB-1:0] wmask, txreq_clr, done_clr, abort_clr, flag_clr;
  logic [0:0]       gflag_q, gflag_set, gflag_clr;
  logic             gmask_q;
  logic             wr_txreq, wr_done, wr_abort, wr_mbmask, wr_txflag, wr_gmask, wr_gflag;
  wire              unused_wbits = &{1'b0, bus_wdata[DATA_W-1:TX_MB]};

  mb_index_decode #(.N_OUT(TX_MB), .IDX_W(IDX_W)) u_done_dec (
    .vld(done_vld), .idx(done_idx), .hit(done_hit));
  mb_index_decode #(.N_OUT(TX_MB), .IDX_W(IDX_W)) u_abort_dec (
    .vld(abort_vld), .idx(abort_idx), .hit(abort_hit));

  // write strobes
  always_comb begin
    wr_txreq  = bus_sel && bus_wr && (bus_addr == RA_TXREQ);
    wr_done   = bus_sel && bus_wr && (bus_addr == RA_DONE);
    wr_abort  = bus_sel && bus_wr && (bus_addr == RA_ABORT);
    wr_mbmask = bus_sel && bus_wr && (bus_addr == RA_MBMASK);
    wr_txflag = bus_sel && bus_wr && (bus_addr == RA_TXFLAG);
    wr_gmask  = bus_sel && bus_wr && (bus_addr == RA_GMASK);
    wr_gflag  = bus_sel && bus_wr && (bus_addr == RA_GFLAG);
    wmask     = bus_wdata[TX_MB-1:0];
  end

  // clear sources: own write-one-to-clear plus transmit-request cross-clear
  always_comb begin
    txreq_clr = wr_txreq  ? wmask : '0;
    done_clr  = (wr_done  ? wmask : '0) | txreq_clr;
    abort_clr = (wr_abort ? wmask : '0) | txreq_clr;
    flag_clr  = wr_txflag ? wmask : '0;
    gflag_set = {|abort_hit};
    gflag_clr = {wr_gflag && bus_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreq_q  <= '0;
      mbmask_q <= '0;
      gmask_q  <= 1'b0;
    end else begin
      if (wr_txreq)  txreq_q  <= wmask;
      if (wr_mbmask) mbmask_q <= wmask;
      if (wr_gmask)  gmask_q  <= bus_wdata[0];
    end
  end

  w1c_status_bank #(.WIDTH(TX_MB)) u_done_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(done_hit), .clr_vec(done_clr), .sts_q(done_sts));
  w1c_status_bank #(.WIDTH(TX_MB)) u_abort_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(abort_hit), .clr_vec(abort_clr), .sts_q(abort_sts));
  w1c_status_bank #(.WIDTH(TX_MB)) u_flag_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(done_hit & mbmask_q), .clr_vec(flag_clr), .sts_q(txflag_q));
  w1c_status_bank #(.WIDTH(1)) u_gflag_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(gflag_set), .clr_vec(gflag_clr), .sts_q(gflag_q));

  assign irq_txdone = |txflag_q;
  assign irq_global = gflag_q[0] & gmask_q;

  // read mux, upper bits zero-extended
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        RA_TXREQ:  bus_rdata[TX_MB-1:0] = txreq_q;
        RA_DONE:   bus_rdata[TX_MB-1:0] = done_sts;
        RA_ABORT:  bus_rdata[TX_MB-1:0] = abort_sts;
        RA_MBMASK: bus_rdata[TX_MB-1:0] = mbmask_q;
        RA_TXFLAG: bus_rdata[TX_MB-1:0] = txflag_q;
        RA_GMASK:  bus_rdata[0]         = gmask_q;
        RA_GFLAG:  bus_rdata[0]         = gflag_q[0];
        default:   bus_rdata            = '0;
      endcase
    end
  end

  // R9
  abort_sets_gflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_vld && (abort_idx < IDX_W'(TX_MB))) |=> gflag_q[0]);

  // R8
  masked_done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && (done_idx < IDX_W'(TX_MB)) && mbmask_q[done_idx]) |=> irq_txdone);

  // R4
  reserved_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && (done_idx == IDX_W'(TX_MB)) && !abort_vld && !(bus_sel && bus_wr))
      |=> ($stable(done_sts) && $stable(txflag_q)));

  // R4
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_hit) && $onehot0(abort_hit));
endmodule

// File: tb/tb_can_tx_status.sv
module tb_can_tx_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_vld = 1'b0, abort_vld = 1'b0;
  logic [4:0]  done_idx = '0, abort_idx = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_txdone, irq_global;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_status dut (
    .clk(clk), .rst_n(rst_n),
    .done_vld(done_vld), .done_idx(done_idx),
    .abort_vld(abort_vld), .abort_idx(abort_idx),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_txdone(irq_txdone), .irq_global(irq_global));

  // bit 5 = abort event, bits 4..0 = mailbox index
  localparam logic [5:0] EV_TAB [8] = '{
    6'h00, 6'h1E, 6'h1F, 6'h3F, 6'h25, 6'h03, 6'h2C, 6'h07 };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic ev(input logic is_abort, input logic [4:0] idx);
    @(negedge clk);
    if (is_abort) begin abort_vld = 1; abort_idx = idx; end
    else begin done_vld = 1; done_idx = idx; end
    @(negedge clk);
    abort_vld = 0; done_vld = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] m_done, m_abort, m_flag;
    logic        m_g;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq_txdone", {31'b0, irq_txdone}, 32'h0);
    chk("R1 irq_global", {31'b0, irq_global}, 32'h0);

    // vector walk, mask low byte for completion flags
    wr(3'd3, 32'h0000_00FF);
    m_done = 0; m_abort = 0; m_g = 0;
    for (int i = 0; i < 8; i++) begin
      ev(EV_TAB[i][5], EV_TAB[i][4:0]);
      if (EV_TAB[i][4:0] != 5'd31) begin
        if (EV_TAB[i][5]) begin m_abort[EV_TAB[i][4:0]] = 1'b1; m_g = 1; end
        else m_done[EV_TAB[i][4:0]] = 1'b1;
      end
      m_flag = m_done & 32'hFF;
      rd(3'd1, v); chk("R2/R4 done status", v, m_done);
      rd(3'd2, v); chk("R3/R4 abort status", v, m_abort);
      rd(3'd4, v); chk("R8 flag reg", v, m_flag);
      rd(3'd6, v); chk("R9/R4 global flag", v, {31'b0, m_g});
    end
    chk("R9 irq_global masked off", {31'b0, irq_global}, 32'h0);

    // R5 write zero / write one
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R5 zero write", v, 32'h4000_0089);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk("R5 one clears", v, 32'h4000_0088);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R5 abort zero write", v, 32'h0000_1020);

    // R6 cross-clear
    wr(3'd0, 32'h4000_0020);
    rd(3'd1, v); chk("R6 done cross-clear", v, 32'h0000_0088);
    rd(3'd2, v); chk("R6 abort cross-clear", v, 32'h0000_1000);
    rd(3'd0, v); chk("R6 txreq readback", v, 32'h4000_0020);
    wr(3'd0, 32'h0);
    rd(3'd1, v); chk("R6 zero no clear", v, 32'h0000_0088);
    rd(3'd2, v); chk("R6 zero no clear abort", v, 32'h0000_1000);

    // R11 reserved bit
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R11 mask bit31", v, 32'h7FFF_FFFF);
    wr(3'd1, 32'h8000_0000);
    rd(3'd1, v); chk("R11 done bit31 write", v, 32'h0000_0088);

    // R8 mask zero blocks flag
    wr(3'd3, 32'h0);
    ev(1'b0, 5'd20);
    rd(3'd1, v); chk("R8 status still sets", v, 32'h0010_0088);
    rd(3'd4, v); chk("R8 masked flag", v, 32'h0000_0089);

    // R7 set and clear collide on bit 3, plain clear on bit 7
    @(negedge clk);
    done_vld = 1; done_idx = 5'd3;
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h88;
    @(negedge clk);
    done_vld = 0; bus_sel = 0; bus_wr = 0;
    rd(3'd1, v); chk("R7 set wins", v, 32'h0010_0008);

    // R10 flag clearing
    chk("R10 irq high", {31'b0, irq_txdone}, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R10 partial clear", v, 32'h88);
    chk("R10 irq stays", {31'b0, irq_txdone}, 32'h1);
    wr(3'd4, 32'h88);
    @(negedge clk);
    chk("R10 irq low", {31'b0, irq_txdone}, 32'h0);

    // R9 global mask and clear
    wr(3'd5, 32'h1);
    @(negedge clk);
    chk("R9 irq_global on", {31'b0, irq_global}, 32'h1);
    wr(3'd6, 32'h1);
    @(negedge clk);
    chk("R9 irq_global off", {31'b0, irq_global}, 32'h0);
    rd(3'd6, v); chk("R9 flag cleared", v, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule